// File: doc/BRIEF.md
# DMX512 Frame Timing Generator

This block turns the contents of an external 512-byte slot buffer into a continuous DMX512 serial stream. A frame consists of a line-low break, a line-high mark-after-break, a character holding the zero start code, and a programmable number of data characters. Every character is a 250 kbaud 8N2 character: one low start bit, eight data bits sent least significant bit first, and two high stop bits. Each bit lasts 4 µs.

All durations are counted in microseconds. A microsecond tick comes from the system clock through a programmable divider. The host sets three values: the number of data slots, an extra idle gap placed between characters, and the refresh period from one break start to the next. When the frame content needs more time than the refresh period allows, the refresh period grows to fit it. The buffer is read through a synchronous port with one cycle of read latency. The address for a slot is presented a full character time before that slot's data is captured.

Generation runs only while the enable input is high. When enable clears, the segment that is in progress runs to its end. After that the line stays in idle, which is high.

Top module: `dmx_frame_gen`

## Requirements
- R1: After reset, and while `en` stays low, `tx` is held high and no break is produced.
- R2: The break holds `tx` low for exactly 176 µs. The mark-after-break that follows holds `tx` high for exactly 12 µs.
- R3: Each character is one low start bit, eight data bits with the LSB first, and two high stop bits, each bit 4 µs long. The first character of every frame carries the value 0x00.
- R4: The time from one start bit to the next start bit within a frame is 44 + `gap_us` µs. With `gap_us` = 0, the characters are sent back to back.
- R5: After the start code, exactly `slot_cnt` data characters follow. Data character k (k = 1..`slot_cnt`) carries the buffer byte at address k-1.
- R6: The time from one break start to the next is max(`period_us`, 188 + 44·(`slot_cnt`+1) + `gap_us`·`slot_cnt`) µs. When the two values are equal, the next break follows the last stop bit with no idle time.
- R7: When `en` rises while the block is idle, a break begins on the next tick. When `en` clears, the current segment (break, mark, character or gap) finishes first. After that `tx` stays high and no further break begins.
- R8: One microsecond equals `us_div`+1 clock cycles, and every duration in R2 to R6 scales by that factor.
- R9: With `slot_cnt` = 0, a frame is a break, a mark and the start code only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Generation enable |
| us_div | input | DIV_W (8) | Clock cycles per microsecond, minus one |
| slot_cnt | input | SLOT_W (10) | Number of data slots after the start code, 0..512 |
| gap_us | input | GAP_W (16) | Extra idle time between characters, in µs |
| period_us | input | PER_W (24) | Break-to-break refresh period, in µs |
| rd_addr | output | ADDR_W (9) | Slot buffer read address |
| rd_data | input | 8 | Slot buffer read data, valid one cycle after the address |
| tx | output | 1 | Serial DMX output line, idle high |

## Verification
The end of the last stop bit and the expiry of the refresh period can fall on the same microsecond tick. In that case the block must go straight into the next break, without a wait step. The bench provokes this with one configuration whose period equals the frame content length exactly, and another whose period is one microsecond longer. It judges both by measuring the break-to-break time on the line. A second collision happens when enable clears in the middle of a character. The bench confirms that the character still completes with its data bits and that the line then stays high.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  typedef enum logic [2:0] {
    SEG_IDLE, SEG_BREAK, SEG_MAB, SEG_SLOT, SEG_GAP, SEG_WAIT
  } seg_e;

  localparam int BREAK_US  = 176;
  localparam int MAB_US    = 12;
  localparam int BIT_US    = 4;
  localparam int CHAR_BITS = 11;
  localparam int CHAR_US   = BIT_US * CHAR_BITS;
endpackage

// File: rtl/dmx_us_tick.sv
module dmx_us_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/dmx_period_ctr.sv
module dmx_period_ctr #(
  parameter int PER_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  output logic             due
);
  logic [PER_W-1:0] elapsed;

  // due once the current tick is the last one of the programmed period
  assign due = ({1'b0, elapsed} + 1'b1) >= {1'b0, period};

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
    end else if (tick) begin
      if (restart)
        elapsed <= '0;
      else if (elapsed != '1)
        elapsed <= elapsed + 1'b1;
    end
  end
endmodule

// File: rtl/dmx_seq.sv
module dmx_seq
  import dmx_pkg::*;
#(
  parameter int SLOT_W = 10,
  parameter int ADDR_W = 9,
  parameter int GAP_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              en,
  input  logic [SLOT_W-1:0] slots,
  input  logic [GAP_W-1:0]  gap,
  input  logic              due,
  input  logic [7:0]        rd_data,
  output seg_e              st,
  output logic [CNT_W-1:0]  cnt,
  output logic [7:0]        cur_byte,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              brk_start
);
  seg_e              nxt;
  logic [CNT_W-1:0]  len_m1;
  logic              seg_end;
  logic              enter_slot;
  logic [SLOT_W-1:0] idx;
  logic [SLOT_W-1:0] idx_nxt;

  always_comb begin
    unique case (st)
      SEG_BREAK: len_m1 = CNT_W'(BREAK_US - 1);
      SEG_MAB:   len_m1 = CNT_W'(MAB_US - 1);
      SEG_SLOT:  len_m1 = CNT_W'(CHAR_US - 1);
      SEG_GAP:   len_m1 = CNT_W'(gap) - 1'b1;
      default:   len_m1 = '0;
    endcase
  end

  assign seg_end = (cnt == len_m1);

  always_comb begin
    nxt = st;
    unique case (st)
      SEG_IDLE:  if (en) nxt = SEG_BREAK;
      SEG_BREAK: if (seg_end) nxt = en ? SEG_MAB : SEG_IDLE;
      SEG_MAB:   if (seg_end) nxt = en ? SEG_SLOT : SEG_IDLE;
      SEG_SLOT: begin
        if (seg_end) begin
          if (!en)                nxt = SEG_IDLE;
          else if (idx == slots)  nxt = due ? SEG_BREAK : SEG_WAIT;
          else if (gap == '0)     nxt = SEG_SLOT;
          else                    nxt = SEG_GAP;
        end
      end
      SEG_GAP:   if (seg_end) nxt = en ? SEG_SLOT : SEG_IDLE;
      SEG_WAIT: begin
        if (!en)      nxt = SEG_IDLE;
        else if (due) nxt = SEG_BREAK;
      end
      default:   nxt = SEG_IDLE;
    endcase
  end

  assign enter_slot = seg_end && (nxt == SEG_SLOT);
  assign idx_nxt    = (st == SEG_MAB) ? '0 : idx + 1'b1;
  assign brk_start  = tick && (nxt == SEG_BREAK) && (st != SEG_BREAK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SEG_IDLE;
      cnt      <= '0;
      idx      <= '0;
      cur_byte <= '0;
      rd_addr  <= '0;
    end else if (tick) begin
      st  <= nxt;
      cnt <= seg_end ? '0 : cnt + 1'b1;
      if (enter_slot) begin
        idx      <= idx_nxt;
        // start code is zero; a data slot takes the byte fetched during the previous slot
        cur_byte <= (st == SEG_MAB) ? 8'h00 : rd_data;
        // address for the slot after the one now starting
        rd_addr  <= idx_nxt[ADDR_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dmx_bit_out.sv
module dmx_bit_out
  import dmx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  seg_e             st,
  input  logic [CNT_W-1:0] cnt,
  input  logic [7:0]       cur_byte,
  output logic             tx
);
  logic [CNT_W-1:0] pos;
  logic [2:0]       bsel;
  logic             tx_d;

  assign pos  = cnt / CNT_W'(BIT_US);
  assign bsel = pos[2:0] - 3'd1;

  always_comb begin
    unique case (st)
      SEG_BREAK: tx_d = 1'b0;
      SEG_SLOT: begin
        if (pos == '0)               tx_d = 1'b0;
        else if (pos <= CNT_W'(8))   tx_d = cur_byte[bsel];
        else                         tx_d = 1'b1;
      end
      default:   tx_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tx <= 1'b1;
    else     tx <= tx_d;
  end
endmodule

// File: rtl/dmx_frame_gen.sv
module dmx_frame_gen
  import dmx_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int SLOT_W = 10,
  parameter int ADDR_W = 9,
  parameter int GAP_W  = 16,
  parameter int PER_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DIV_W-1:0]  us_div,
  input  logic [SLOT_W-1:0] slot_cnt,
  input  logic [GAP_W-1:0]  gap_us,
  input  logic [PER_W-1:0]  period_us,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              tx
);
  localparam int CNT_W = (GAP_W > 8) ? GAP_W : 8;

  logic             tick;
  logic             due;
  logic             brk_start;
  seg_e             st;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       cur_byte;

  dmx_us_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div(us_div), .tick(tick)
  );

  dmx_period_ctr #(.PER_W(PER_W)) u_per (
    .clk(clk), .rst(rst), .tick(tick), .restart(brk_start),
    .period(period_us), .due(due)
  );

  dmx_seq #(
    .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .GAP_W(GAP_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .en(en), .slots(slot_cnt),
    .gap(gap_us), .due(due), .rd_data(rd_data), .st(st), .cnt(cnt),
    .cur_byte(cur_byte), .rd_addr(rd_addr), .brk_start(brk_start)
  );

  dmx_bit_out #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .st(st), .cnt(cnt), .cur_byte(cur_byte), .tx(tx)
  );
endmodule

// File: rtl/dmx_frame_gen_chk.sv
module dmx_frame_gen_chk
  import dmx_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic en,
  input logic tick,
  input seg_e st,
  input logic tx
);
  logic [7:0] brk_n;
  logic [7:0] mab_n;

  always_ff @(posedge clk) begin
    if (rst || st != SEG_BREAK) brk_n <= '0;
    else if (tick)              brk_n <= brk_n + 1'b1;
    if (rst || st != SEG_MAB)   mab_n <= '0;
    else if (tick)              mab_n <= mab_n + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (tx && st == SEG_IDLE));

  assert_break_len_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(st) == SEG_BREAK && st != SEG_BREAK) |-> brk_n == 8'(BREAK_US));

  assert_mab_len_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(st) == SEG_MAB && st != SEG_MAB) |-> mab_n == 8'(MAB_US));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (st == SEG_IDLE && !en) |=> st == SEG_IDLE);

  assert_tick_paced_R8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(st));
endmodule

bind dmx_frame_gen dmx_frame_gen_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .tick(tick), .st(st), .tx(tx)
);

// File: tb/sim_dmx_frame_gen.sv
module sim_dmx_frame_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [7:0]  us_div = '0;
  logic [9:0]  slot_cnt = '0;
  logic [15:0] gap_us = '0;
  logic [23:0] period_us = '0;
  logic [8:0]  rd_addr;
  logic [7:0]  rd_data;
  logic        tx;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [7:0] mem [512];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) rd_data <= mem[rd_addr];

  dmx_frame_gen u0 (
    .clk(clk), .rst(rst), .en(en), .us_div(us_div), .slot_cnt(slot_cnt),
    .gap_us(gap_us), .period_us(period_us), .rd_addr(rd_addr),
    .rd_data(rd_data), .tx(tx)
  );

  // fields: slots[63:48] gap[47:32] period[31:8] div[7:0]
  localparam logic [63:0] VEC [7] = '{
    {16'd3,   16'd0, 24'd100,   8'd0},
    {16'd2,   16'd5, 24'd1000,  8'd0},
    {16'd0,   16'd0, 24'd0,     8'd1},
    {16'd4,   16'd3, 24'd500,   8'd2},
    {16'd2,   16'd5, 24'd330,   8'd0},
    {16'd2,   16'd5, 24'd331,   8'd0},
    {16'd512, 16'd0, 24'd25000, 8'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // called with tx low at the first sample of a break; returns next break start
  task automatic grab_frame(input int n, input int gap, input int d, output int nb);
    int lowc, highc, prev, ts, off, target;
    logic [7:0] v;
    bit fmt_ok;
    lowc = 0; highc = 0; prev = 0;
    while (tx == 1'b0) begin @(negedge clk); lowc++; end
    chk(lowc == 176 * d, "R2 break", lowc, 176 * d);
    while (tx == 1'b1) begin @(negedge clk); highc++; end
    chk(highc == 12 * d, "R2 mab", highc, 12 * d);
    for (int s = 0; s <= n; s++) begin
      ts = cyc;
      if (s > 0) chk(ts - prev == (44 + gap) * d, "R4 spacing", ts - prev, (44 + gap) * d);
      prev = ts;
      off = 0; fmt_ok = 1'b1; v = '0;
      for (int b = 0; b < 11; b++) begin
        target = (b * 4 + 2) * d;
        while (off < target) begin @(negedge clk); off++; end
        if (b == 0) fmt_ok &= (tx == 1'b0);
        else if (b <= 8) v[b-1] = tx;
        else fmt_ok &= (tx == 1'b1);
      end
      chk(fmt_ok, "R3 start/stop bits", int'(fmt_ok), 1);
      if (s == 0) chk(v == 8'h00, "R3 start code", v, 0);
      else chk(v == mem[s-1], "R5 slot data", v, mem[s-1]);
      while (tx == 1'b1) @(negedge clk);
    end
    nb = cyc;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    int t0, nb, lat, lows, exp_l, exp_p, n, g, p, d;
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + 11);

    // R1: reset and idle with enable low
    step(3);
    chk(tx == 1'b1, "R1 reset level", tx, 1);
    rst = 1'b0;
    lows = 0;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (!tx) lows++; end
    chk(lows == 0, "R1 idle while disabled", lows, 0);

    // table walk: R2..R6, R8, R9
    for (int v = 0; v < 7; v++) begin
      n = int'(VEC[v][63:48]); g = int'(VEC[v][47:32]);
      p = int'(VEC[v][31:8]);  d = int'(VEC[v][7:0]) + 1;
      rst = 1'b1; en = 1'b0;
      slot_cnt = 10'(n); gap_us = 16'(g); period_us = 24'(p); us_div = 8'(d - 1);
      step(3);
      rst = 1'b0;
      en = 1'b1;
      lat = 0;
      while (tx == 1'b1 && lat < 50) begin @(negedge clk); lat++; end
      if (v == 0) chk(lat <= 3, "R7 start latency", lat, 3);
      t0 = cyc;
      grab_frame(n, g, d, nb);
      exp_l = 188 + 44 * (n + 1) + g * n;
      exp_p = ((p > exp_l) ? p : exp_l) * d;
      chk(nb - t0 == exp_p, (n == 0) ? "R9 R6 refresh" : "R6 R8 refresh", nb - t0, exp_p);
      en = 1'b0;
      step(2);
    end

    // R7: enable cleared mid-character
    rst = 1'b1; en = 1'b0;
    slot_cnt = 10'd4; gap_us = '0; period_us = '0; us_div = '0;
    step(3);
    rst = 1'b0; en = 1'b1;
    while (tx == 1'b1) @(negedge clk);
    while (tx == 1'b0) @(negedge clk);
    while (tx == 1'b1) @(negedge clk);
    t0 = cyc;
    step(10);
    en = 1'b0;
    while (cyc - t0 < 30) @(negedge clk);
    chk(tx == 1'b0, "R7 character completes", tx, 0);
    while (cyc - t0 < 46) @(negedge clk);
    lows = 0;
    for (int i = 0; i < 1000; i++) begin @(negedge clk); if (!tx) lows++; end
    chk(lows == 0, "R7 idle after disable", lows, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule